// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical raster timing for a video pipeline that runs entirely from one master clock. It divides the master clock twice. One fixed divide-by-six enable steps the horizontal (line) counter. A second enable forms the pixel strobe, and its divisor depends on the selected pixel-width mode: divide-by-five for the narrow 384-pixel mode and divide-by-four for the wide 496-pixel mode. The line counter never follows the pixel mode, so the line rate is the same in both modes.

Software programs five values through a simple write port: horizontal total, vertical total, horizontal active end, vertical active end and pixel mode. Each horizontal and area value gives the last count of its span, so the true span is the value plus one. The vertical total is the exception: a frame holds the value plus two lines. Writes go to a pending set. The pending set is copied into the working set only at the frame wrap, so every frame runs with one consistent geometry. The vertical region is tracked by a two-state machine. In `VS_ACTIVE` the raster is in visible lines, and in `VS_BLANK` it is in vertical blanking. The *enter-blank* transition (`VS_ACTIVE` to `VS_BLANK`) fires when the line counter wraps on the last active line, and it raises a one-cycle vblank-start pulse that can serve as an interrupt. The *new-frame* transition (`VS_BLANK` to `VS_ACTIVE`) fires at the frame wrap.

After reset the geometry is the standard 15 kHz layout. The horizontal total is 454, giving 455 ticks and 2730 master clocks per line. The vertical total is 262, giving 264 lines. The visible area is 224 lines. The horizontal active end is 319 ticks, which matches 384 pixels at divide-by-five.

Top module: `crtc_timing_gen`

## Requirements
- R1: After synchronous reset `hcnt` and `vcnt` are 0, and `hblank`, `vblank`, `vblank_start` and `pix_stb` are all 0. The working geometry is horizontal total 454, vertical total 262, horizontal active end 319, vertical active end 223, with the narrow pixel mode.
- R2: `hcnt` advances only once every 6 master clocks, so a line lasts (horizontal total + 1) × 6 master clocks: 2730 by default and 1764 with a total of 293.
- R3: `hcnt` counts 0 up to the horizontal total and then returns to 0. `vcnt` advances by one on each such return.
- R4: `vcnt` counts 0 up to vertical total + 1 and then returns to 0, so a frame holds vertical total + 2 lines: 264 for a value of 262 and 426 for a value of 424.
- R5: `hblank` is 1 exactly when `hcnt` is greater than the horizontal active end.
- R6: `vblank` is 1 exactly when `vcnt` is greater than the vertical active end. `vblank_start` is high for one master clock, in the first cycle where `vcnt` equals the vertical active end + 1.
- R7: `pix_stb` pulses once every 5 master clocks in the narrow mode (mode bit 0) and once every 4 in the wide mode (mode bit 1). The line length does not change with the mode. The pixel divider restarts at each frame wrap.
- R8: A write with `wr_en` high stores `wr_data` by `wr_sel`: 0 horizontal total, 1 vertical total, 2 horizontal active end, 3 vertical active end, 4 mode (bit 0). Selector codes 5 to 7 store nothing. Stored values govern the outputs only from the frame after the next frame wrap; the current frame keeps its geometry and its pixel rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register selector (0..4) |
| wr_data | input | W (10) | Register write value |
| hcnt | output | W (10) | Horizontal (line tick) counter |
| vcnt | output | W (10) | Vertical line counter |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |
| vblank_start | output | 1 | One-cycle pulse on entering vertical blanking |
| pix_stb | output | 1 | Pixel clock enable |

## Verification
The situation hardest to reach from the ports is a full frame boundary. A standard frame lasts 720,720 master clocks, and new geometry only appears after one. The bench therefore adds a second instance whose reset-time horizontal total is 4, so each line lasts 30 clocks while the vertical total stays 262. On that instance the bench writes the 24 kHz vertical values and the wide mode in the middle of the first frame. It then confirms that this frame keeps 264 lines, blanks at line 224 and keeps a 5-clock pixel rate, and that the next frame has 426 lines, blanks at line 384 and strobes every 4 clocks. A horizontal total of 293 is written during that second frame, and the first line of the third frame is timed at 1764 clocks. The standard 2730-clock line is timed on the instance that keeps the true reset geometry.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

    // register selector codes on the write port
    typedef enum logic [2:0] {
        SEL_HTOTAL = 3'd0,
        SEL_VTOTAL = 3'd1,
        SEL_HACT   = 3'd2,
        SEL_VACT   = 3'd3,
        SEL_MODE   = 3'd4
    } reg_sel_e;

    // pixel-width mode
    typedef enum logic {
        MODE_NARROW = 1'b0,
        MODE_WIDE   = 1'b1
    } pix_mode_e;

    // vertical region state
    typedef enum logic {
        VS_ACTIVE = 1'b0,
        VS_BLANK  = 1'b1
    } vstate_e;

endpackage

// File: rtl/crtc_clk_div.sv
module crtc_clk_div #(
    parameter int DW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [DW-1:0] div,
    output logic          tick
);

    logic [DW-1:0] cnt;

    // tick in the last cycle of each period
    always_comb begin
        tick = (cnt >= (div - DW'(1)));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DW'(1);
        end
    end

endmodule

// File: rtl/crtc_geom_regs.sv
module crtc_geom_regs
    import crtc_pkg::*;
#(
    parameter int W          = 10,
    parameter int DEF_HTOTAL = 454,
    parameter int DEF_VTOTAL = 262,
    parameter int DEF_HACT   = 319,
    parameter int DEF_VACT   = 223,
    parameter int DEF_MODE   = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [2:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         frame_wrap,
    output logic [W-1:0] act_htotal,
    output logic [W-1:0] act_vtotal,
    output logic [W-1:0] act_hact,
    output logic [W-1:0] act_vact,
    output pix_mode_e    act_mode
);

    logic [W-1:0] pend_htotal;
    logic [W-1:0] pend_vtotal;
    logic [W-1:0] pend_hact;
    logic [W-1:0] pend_vact;
    pix_mode_e    pend_mode;

    // pending set: written at any time
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_htotal <= W'(DEF_HTOTAL);
            pend_vtotal <= W'(DEF_VTOTAL);
            pend_hact   <= W'(DEF_HACT);
            pend_vact   <= W'(DEF_VACT);
            pend_mode   <= pix_mode_e'(DEF_MODE[0]);
        end else if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_HTOTAL: pend_htotal <= wr_data;
                SEL_VTOTAL: pend_vtotal <= wr_data;
                SEL_HACT:   pend_hact   <= wr_data;
                SEL_VACT:   pend_vact   <= wr_data;
                SEL_MODE:   pend_mode   <= pix_mode_e'(wr_data[0]);
                default: ;
            endcase
        end
    end

    // working set: copied only at the frame wrap
    always_ff @(posedge clk) begin
        if (rst) begin
            act_htotal <= W'(DEF_HTOTAL);
            act_vtotal <= W'(DEF_VTOTAL);
            act_hact   <= W'(DEF_HACT);
            act_vact   <= W'(DEF_VACT);
            act_mode   <= pix_mode_e'(DEF_MODE[0]);
        end else if (frame_wrap) begin
            act_htotal <= pend_htotal;
            act_vtotal <= pend_vtotal;
            act_hact   <= pend_hact;
            act_vact   <= pend_vact;
            act_mode   <= pend_mode;
        end
    end

endmodule

// File: rtl/crtc_raster.sv
module crtc_raster
    import crtc_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         line_tick,
    input  logic [W-1:0] htotal,
    input  logic [W-1:0] vtotal,
    input  logic [W-1:0] hact,
    input  logic [W-1:0] vact,
    output logic [W-1:0] hcnt,
    output logic [W-1:0] vcnt,
    output logic         hblank,
    output logic         vblank,
    output logic         vbl_start,
    output logic         frame_wrap
);

    localparam int VW = W + 1;

    vstate_e state;
    vstate_e state_nx;
    logic    h_wrap;
    logic    enter_blank;

    always_comb begin
        h_wrap      = line_tick && (hcnt == htotal);
        frame_wrap  = h_wrap && ({1'b0, vcnt} == ({1'b0, vtotal} + VW'(1)));
        enter_blank = h_wrap && !frame_wrap && (vcnt == vact);
    end

    // counters
    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (line_tick) begin
            if (h_wrap) begin
                hcnt <= '0;
                vcnt <= frame_wrap ? '0 : vcnt + W'(1);
            end else begin
                hcnt <= hcnt + W'(1);
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= VS_ACTIVE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions: enter-blank, new-frame
    always_comb begin
        state_nx = state;
        unique case (state)
            VS_ACTIVE: if (enter_blank) state_nx = VS_BLANK;
            VS_BLANK:  if (frame_wrap)  state_nx = VS_ACTIVE;
        endcase
    end

    // outputs
    always_comb begin
        vblank = (state == VS_BLANK);
        hblank = (hcnt > hact);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vbl_start <= 1'b0;
        end else begin
            vbl_start <= enter_blank;
        end
    end

endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
    import crtc_pkg::*;
#(
    parameter int W              = 10,
    parameter int LINE_DIV       = 6,
    parameter int PIX_DIV_NARROW = 5,
    parameter int PIX_DIV_WIDE   = 4,
    parameter int DEF_HTOTAL     = 454,
    parameter int DEF_VTOTAL     = 262,
    parameter int DEF_HACT       = 319,
    parameter int DEF_VACT       = 223,
    parameter int DEF_MODE       = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [2:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] hcnt,
    output logic [W-1:0] vcnt,
    output logic         hblank,
    output logic         vblank,
    output logic         vblank_start,
    output logic         pix_stb
);

    localparam int MAX_DIV = (LINE_DIV > PIX_DIV_NARROW)
                           ? ((LINE_DIV > PIX_DIV_WIDE) ? LINE_DIV : PIX_DIV_WIDE)
                           : ((PIX_DIV_NARROW > PIX_DIV_WIDE) ? PIX_DIV_NARROW : PIX_DIV_WIDE);
    localparam int DIV_W   = $clog2(MAX_DIV + 1);

    logic [W-1:0]     act_htotal;
    logic [W-1:0]     act_vtotal;
    logic [W-1:0]     act_hact;
    logic [W-1:0]     act_vact;
    pix_mode_e        act_mode;
    logic             line_tick;
    logic             frame_wrap;
    logic [DIV_W-1:0] line_div;
    logic [DIV_W-1:0] pix_div;

    always_comb begin
        line_div = DIV_W'(LINE_DIV);
        pix_div  = (act_mode == MODE_WIDE) ? DIV_W'(PIX_DIV_WIDE) : DIV_W'(PIX_DIV_NARROW);
    end

    crtc_geom_regs #(
        .W(W), .DEF_HTOTAL(DEF_HTOTAL), .DEF_VTOTAL(DEF_VTOTAL),
        .DEF_HACT(DEF_HACT), .DEF_VACT(DEF_VACT), .DEF_MODE(DEF_MODE)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .frame_wrap(frame_wrap),
        .act_htotal(act_htotal), .act_vtotal(act_vtotal),
        .act_hact(act_hact), .act_vact(act_vact), .act_mode(act_mode)
    );

    // fixed line-rate enable, independent of the pixel mode
    crtc_clk_div #(.DW(DIV_W)) u_line_div (
        .clk(clk), .rst(rst), .clr(1'b0), .div(line_div), .tick(line_tick)
    );

    // pixel enable, restarted at every frame wrap
    crtc_clk_div #(.DW(DIV_W)) u_pix_div (
        .clk(clk), .rst(rst), .clr(frame_wrap), .div(pix_div), .tick(pix_stb)
    );

    crtc_raster #(.W(W)) u_raster (
        .clk(clk), .rst(rst), .line_tick(line_tick),
        .htotal(act_htotal), .vtotal(act_vtotal), .hact(act_hact), .vact(act_vact),
        .hcnt(hcnt), .vcnt(vcnt), .hblank(hblank), .vblank(vblank),
        .vbl_start(vblank_start), .frame_wrap(frame_wrap)
    );

endmodule

// File: rtl/crtc_timing_chk.sv
module crtc_timing_chk #(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] hcnt,
    input logic [W-1:0] vcnt,
    input logic         line_tick,
    input logic         pix_stb,
    input logic         vbl_start,
    input logic         vblank,
    input logic         frame_wrap,
    input logic [W-1:0] act_htotal,
    input logic [W-1:0] act_vtotal,
    input logic [W-1:0] act_vact
);

    // R3
    hcnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        hcnt <= act_htotal);

    // R4
    vcnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        {1'b0, vcnt} <= ({1'b0, act_vtotal} + (W+1)'(1)));

    // R2
    hcnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !line_tick |=> $stable(hcnt));

    // R6
    vbl_start_once_chk: assert property (@(posedge clk) disable iff (rst)
        vbl_start |=> !vbl_start);

    // R6
    vbl_start_line_chk: assert property (@(posedge clk) disable iff (rst)
        vbl_start |-> (vblank && ({1'b0, vcnt} == ({1'b0, act_vact} + (W+1)'(1)))));

    // R7
    pix_gap_chk: assert property (@(posedge clk) disable iff (rst)
        pix_stb |=> !pix_stb);

    // R8
    geom_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_wrap |=> ($stable(act_vtotal) && $stable(act_htotal) && $stable(act_vact)));

endmodule

bind crtc_timing_gen crtc_timing_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt), .line_tick(line_tick),
    .pix_stb(pix_stb), .vbl_start(vblank_start), .vblank(vblank),
    .frame_wrap(frame_wrap), .act_htotal(act_htotal), .act_vtotal(act_vtotal),
    .act_vact(act_vact)
);

// File: tb/crtc_timing_gen_test.sv
module crtc_timing_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    int         total = 0;
    int         bad = 0;
    int         cyc = 0;

    // instance A: true reset geometry
    logic [9:0] a_hcnt, a_vcnt;
    logic       a_hblank, a_vblank, a_vbs, a_pix;
    // instance B: short lines for frame-level tests
    logic       b_wr_en = 1'b0;
    logic [2:0] b_sel = 3'd0;
    logic [9:0] b_data = 10'd0;
    logic [9:0] b_hcnt, b_vcnt;
    logic       b_hblank, b_vblank, b_vbs, b_pix;

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

    crtc_timing_gen uut (
        .clk(clk), .rst(rst), .wr_en(1'b0), .wr_sel(3'd0), .wr_data(10'd0),
        .hcnt(a_hcnt), .vcnt(a_vcnt), .hblank(a_hblank), .vblank(a_vblank),
        .vblank_start(a_vbs), .pix_stb(a_pix)
    );

    crtc_timing_gen #(.DEF_HTOTAL(4), .DEF_HACT(2)) uut_fast (
        .clk(clk), .rst(rst), .wr_en(b_wr_en), .wr_sel(b_sel), .wr_data(b_data),
        .hcnt(b_hcnt), .vcnt(b_vcnt), .hblank(b_hblank), .vblank(b_vblank),
        .vblank_start(b_vbs), .pix_stb(b_pix)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_b(input logic [2:0] s, input logic [9:0] d);
        @(negedge clk);
        b_wr_en = 1'b1; b_sel = s; b_data = d;
        @(negedge clk);
        b_wr_en = 1'b0;
    endtask

    // measures pixel strobe spacing on instance B
    task automatic t_pix(input string req, input int exp);
        int last = -1;
        int n = 0;
        int errs = 0;
        int gap = 0;
        while (n < 12) begin
            @(negedge clk);
            if (b_pix) begin
                if (last >= 0) begin
                    gap = cyc - last;
                    if (gap != exp) errs++;
                end
                last = cyc;
                n++;
            end
        end
        check({req, " pixel gap"}, gap, exp);
        check({req, " pixel gap errors"}, errs, 0);
    endtask

    task automatic t_reset;
        check("R1 hcnt", a_hcnt, 0);
        check("R1 vcnt", a_vcnt, 0);
        check("R1 hblank", a_hblank, 0);
        check("R1 vblank", a_vblank, 0);
        check("R1 vblank_start", a_vbs, 0);
        check("R1 pix_stb", a_pix, 0);
        check("R1 fast vcnt", b_vcnt, 0);
    endtask

    // standard line on instance A: 2730 clocks, hblank after tick 319
    task automatic t_line_std;
        int prev = 0;
        int wrap_cyc = -1;
        int maxh = 0;
        int hb_err = 0;
        while (wrap_cyc < 0) begin
            @(negedge clk);
            if (int'(a_hcnt) > maxh) maxh = a_hcnt;
            if (a_hblank !== (a_hcnt > 10'd319)) hb_err++;
            if (prev != 0 && a_hcnt == 0) wrap_cyc = cyc;
            prev = a_hcnt;
        end
        check("R2 standard line clocks", wrap_cyc, 2730);
        check("R3 hcnt peak", maxh, 454);
        check("R3 vcnt after wrap", a_vcnt, 1);
        check("R5 hblank relation", hb_err, 0);
        check("R6 no vblank on line 1", a_vblank, 0);
    endtask

    // frame A on B: writes mid-frame must not change it
    task automatic t_frame_std;
        int prev;
        int wrap_cyc = -1;
        int pulses = 0;
        int pulse_v = -1;
        int vb_err = 0;
        int hb_err = 0;
        int maxv = 0;
        wr_b(3'd1, 10'd424);
        wr_b(3'd3, 10'd383);
        wr_b(3'd4, 10'd1);
        wr_b(3'd6, 10'd7);
        t_pix("R8 pending mode unused", 5);
        prev = b_vcnt;
        while (wrap_cyc < 0) begin
            @(negedge clk);
            if (int'(b_vcnt) > maxv) maxv = b_vcnt;
            if (b_vblank !== (b_vcnt > 10'd223)) vb_err++;
            if (b_hblank !== (b_hcnt > 10'd2)) hb_err++;
            if (b_vbs) begin pulses++; pulse_v = b_vcnt; end
            if (prev != 0 && b_vcnt == 0) wrap_cyc = cyc;
            prev = b_vcnt;
        end
        check("R4 R8 264-line frame clocks", wrap_cyc, 264 * 30);
        check("R4 vcnt peak", maxv, 263);
        check("R6 pulse count", pulses, 1);
        check("R6 pulse line", pulse_v, 224);
        check("R6 vblank relation", vb_err, 0);
        check("R5 short hblank relation", hb_err, 0);
    endtask

    // frame B on B: new geometry and wide pixel mode
    task automatic t_frame_alt;
        int base = cyc;
        int prev;
        int hprev;
        int wrap_cyc = -1;
        int pulses = 0;
        int pulse_v = -1;
        int vb_err = 0;
        int hw0 = -1;
        int hw1 = -1;
        t_pix("R7 wide mode", 4);
        wr_b(3'd0, 10'd293);
        prev = b_vcnt;
        hprev = b_hcnt;
        while (wrap_cyc < 0) begin
            @(negedge clk);
            if (b_vblank !== (b_vcnt > 10'd383)) vb_err++;
            if (b_vbs) begin pulses++; pulse_v = b_vcnt; end
            if (hprev != 0 && b_hcnt == 0) begin
                if (hw0 < 0) hw0 = cyc;
                else if (hw1 < 0) hw1 = cyc;
            end
            if (prev != 0 && b_vcnt == 0) wrap_cyc = cyc;
            prev = b_vcnt;
            hprev = b_hcnt;
        end
        check("R4 426-line frame clocks", wrap_cyc - base, 426 * 30);
        check("R7 line clocks in wide mode", hw1 - hw0, 30);
        check("R6 pulse count alt", pulses, 1);
        check("R6 pulse line alt", pulse_v, 384);
        check("R6 vblank relation alt", vb_err, 0);
    endtask

    // first line of frame C on B: 1764 clocks
    task automatic t_line_alt;
        int base = cyc;
        int prev = 0;
        int wrap_cyc = -1;
        int maxh = 0;
        while (wrap_cyc < 0) begin
            @(negedge clk);
            if (int'(b_hcnt) > maxh) maxh = b_hcnt;
            if (prev != 0 && b_hcnt == 0) wrap_cyc = cyc;
            prev = b_hcnt;
        end
        check("R2 24k line clocks", wrap_cyc - base, 1764);
        check("R3 hcnt peak alt", maxh, 293);
        check("R3 vcnt after wrap alt", b_vcnt, 1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_line_std();
        t_frame_std();
        t_frame_alt();
        t_line_alt();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule